// File: doc/BRIEF.md
# Secondary Scan Port Park Controller

This block owns the test-mode-select line that a scan bridge drives into one of its secondary JTAG chains. While the chain is not in use, the block parks it by holding that line at a fixed level. The level keeps the chain's TAP controllers in one of four resting states: Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR. When the chain is wanted again, the block reconnects it to the backplane select line. It does this only once the bridge's own TAP controller is about to enter the state the chain is resting in, so that both controllers move in step afterwards.

The block runs from the backplane test clock and makes every decision on the falling edge, so the local line is stable when the local TAPs sample it on the rising edge. The bridge supplies its current and next TAP states and single-cycle request strobes from its instruction decoder: four park requests, one unpark request and one soft reset. The block reports whether the port is parked, waiting for synchronization or connected. All pins are plain control and status signals, and none of them carries a data stream.

Top module: `sec_port_park_ctrl`

## Requirements
- R1: While `trst_n` is low, `port_status` is 2'b00 (parked) and `lcl_tms` is 1. This holds at once, without waiting for a clock edge.
- R2: At any falling edge where `tap_state` is 4'd0 (Test-Logic-Reset), the port becomes parked in Test-Logic-Reset. This rule takes priority over every request strobe.
- R3: A port parked in Test-Logic-Reset drives `lcl_tms` to 1. A port parked in Run-Test/Idle (4'd1), Pause-DR (4'd6) or Pause-IR (4'd13) drives it to 0. In both cases `bp_tms` has no effect on `lcl_tms`.
- R4: An unpark strobe seen at a falling edge while parked moves the port to waiting (2'b01). While waiting, `lcl_tms` is 0.
- R5: A waiting port connects at the first falling edge where `tap_next` equals its synchronization state, and stays waiting at every other edge. The synchronization state is Run-Test/Idle (4'd1) for a port parked in Test-Logic-Reset or Run-Test/Idle, Pause-DR (4'd6) for Pause-DR, and Pause-IR (4'd13) for Pause-IR.
- R6: While connected (2'b10), `lcl_tms` equals `bp_tms` combinationally, so the local TAPs follow the same state sequence as the bridge TAP.
- R7: A park request for Run-Test/Idle, Pause-DR or Pause-IR made while connected is held pending. It takes effect at the first falling edge where `tap_next` equals the requested state, and the port stays connected until then.
- R8: A park-in-Test-Logic-Reset request made while connected parks the port at that falling edge. Every park request made while parked or waiting is ignored, and so is an unpark request made while connected or waiting.
- R9: A soft-reset strobe parks the port in Test-Logic-Reset from any status. The local TAPs then reach Test-Logic-Reset within five test-clock cycles.
- R10: `port_status` and the parked level change only on falling edges of `tck` or on assertion of `trst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| bp_tms | input | 1 | Backplane test-mode-select |
| tap_state | input | 4 | Current state of the bridge TAP |
| tap_next | input | 4 | Next state of the bridge TAP |
| req_park_tlr | input | 1 | Strobe: park in Test-Logic-Reset |
| req_park_rti | input | 1 | Strobe: park in Run-Test/Idle |
| req_park_pdr | input | 1 | Strobe: park in Pause-DR |
| req_park_pir | input | 1 | Strobe: park in Pause-IR |
| req_unpark | input | 1 | Strobe: reconnect the chain |
| req_soft_rst | input | 1 | Strobe: soft reset of the local chain |
| lcl_tms | output | 1 | Test-mode-select to the local chain |
| port_status | output | 2 | 00 parked, 01 waiting, 10 connected |

## Verification
Directed sequences unpark the chain from each resting kind. The bridge is walked past the wrong synchronization state before it reaches the right one, which shows whether the block matches the park kind or connects at any idle state. Pending pause parks are issued while the bridge is several states away from the pause state, which shows whether a park is deferred correctly or applied too early. Random backplane select patterns with mixed request strobes run a model of the local TAP alongside the bridge model. Any connection made at the wrong moment shows up as the two state sequences drifting apart.

// File: rtl/spp_pkg.sv
package spp_pkg;

  localparam int TAP_W = 4;

  typedef enum logic [TAP_W-1:0] {
    TS_TLR = 4'd0,  TS_RTI = 4'd1,  TS_SDR = 4'd2,  TS_CDR = 4'd3,
    TS_SHD = 4'd4,  TS_E1D = 4'd5,  TS_PDR = 4'd6,  TS_E2D = 4'd7,
    TS_UDR = 4'd8,  TS_SIR = 4'd9,  TS_CIR = 4'd10, TS_SHI = 4'd11,
    TS_E1I = 4'd12, TS_PIR = 4'd13, TS_E2I = 4'd14, TS_UIR = 4'd15
  } tap_st_e;

  typedef enum logic [1:0] {
    PK_TLR = 2'd0, PK_RTI = 2'd1, PK_PDR = 2'd2, PK_PIR = 2'd3
  } park_kind_e;

  typedef enum logic [1:0] {
    LS_PARKED = 2'b00, LS_WAIT = 2'b01, LS_CONN = 2'b10
  } link_st_e;

  // TAP state the chain rests in for a given park kind
  function automatic tap_st_e rest_state(park_kind_e k);
    case (k)
      PK_RTI:  return TS_RTI;
      PK_PDR:  return TS_PDR;
      PK_PIR:  return TS_PIR;
      default: return TS_TLR;
    endcase
  endfunction

  // TAP state in which a waiting chain rejoins the bridge
  function automatic tap_st_e sync_state(park_kind_e k);
    case (k)
      PK_PDR:  return TS_PDR;
      PK_PIR:  return TS_PIR;
      default: return TS_RTI;
    endcase
  endfunction

endpackage

// File: rtl/spp_target_match.sv
module spp_target_match
  import spp_pkg::*;
#(
  parameter bit SYNC_SIDE = 1'b1
) (
  input  park_kind_e             kind,
  input  logic [TAP_W-1:0]       tap_next,
  output logic                   hit
);

  generate
    if (SYNC_SIDE) begin : g_sync
      assign hit = (tap_next == sync_state(kind));
    end else begin : g_rest
      assign hit = (tap_next == rest_state(kind));
    end
  endgenerate

endmodule

// File: rtl/spp_park_fsm.sv
module spp_park_fsm
  import spp_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic [TAP_W-1:0] tap_state,
  input  logic             req_park_tlr,
  input  logic             req_park_rti,
  input  logic             req_park_pdr,
  input  logic             req_park_pir,
  input  logic             req_unpark,
  input  logic             req_soft_rst,
  input  logic             sync_hit,
  input  logic             park_hit,
  output park_kind_e       eff_kind,
  output link_st_e         mode_q,
  output park_kind_e       kind_q
);

  logic       pend_q, pend_d, eff_valid;
  park_kind_e pkind_q, pkind_d, kind_d;
  link_st_e   mode_d;
  logic       force_tlr;

  assign force_tlr = (tap_state == TS_TLR) || req_soft_rst;

  // a fresh request overrides an older pending one
  always_comb begin
    eff_valid = pend_q;
    eff_kind  = pkind_q;
    if (req_park_rti) begin
      eff_valid = 1'b1;
      eff_kind  = PK_RTI;
    end else if (req_park_pdr) begin
      eff_valid = 1'b1;
      eff_kind  = PK_PDR;
    end else if (req_park_pir) begin
      eff_valid = 1'b1;
      eff_kind  = PK_PIR;
    end
  end

  always_comb begin
    mode_d  = mode_q;
    kind_d  = kind_q;
    pend_d  = pend_q;
    pkind_d = pkind_q;
    if (force_tlr) begin
      mode_d = LS_PARKED;
      kind_d = PK_TLR;
      pend_d = 1'b0;
    end else begin
      case (mode_q)
        LS_CONN: begin
          if (req_park_tlr) begin
            mode_d = LS_PARKED;
            kind_d = PK_TLR;
            pend_d = 1'b0;
          end else if (eff_valid) begin
            if (park_hit) begin
              mode_d = LS_PARKED;
              kind_d = eff_kind;
              pend_d = 1'b0;
            end else begin
              pend_d  = 1'b1;
              pkind_d = eff_kind;
            end
          end
        end
        LS_PARKED: if (req_unpark) mode_d = LS_WAIT;
        LS_WAIT:   if (sync_hit) mode_d = LS_CONN;
        default: begin
          mode_d = LS_PARKED;
          kind_d = PK_TLR;
          pend_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      mode_q  <= LS_PARKED;
      kind_q  <= PK_TLR;
      pend_q  <= 1'b0;
      pkind_q <= PK_TLR;
    end else begin
      mode_q  <= mode_d;
      kind_q  <= kind_d;
      pend_q  <= pend_d;
      pkind_q <= pkind_d;
    end
  end

  AST_TLR_PARKS: assert property (@(negedge tck) disable iff (!trst_n)
    (tap_state == TS_TLR) |=> (mode_q == LS_PARKED && kind_q == PK_TLR)); // R2

  AST_SOFT_PARKS: assert property (@(negedge tck) disable iff (!trst_n)
    req_soft_rst |=> (mode_q == LS_PARKED && kind_q == PK_TLR)); // R9

  AST_UNPARK_WAITS: assert property (@(negedge tck) disable iff (!trst_n)
    (mode_q == LS_PARKED && req_unpark && !force_tlr) |=> (mode_q == LS_WAIT)); // R4

  AST_SYNC_CONNECTS: assert property (@(negedge tck) disable iff (!trst_n)
    (mode_q == LS_WAIT && sync_hit && !force_tlr) |=> (mode_q == LS_CONN)); // R5

  AST_NO_DIRECT_CONN: assert property (@(negedge tck) disable iff (!trst_n)
    (mode_q == LS_PARKED) |=> (mode_q != LS_CONN)); // R8

  AST_PARKED_STAYS: assert property (@(negedge tck) disable iff (!trst_n)
    (mode_q == LS_PARKED && !req_unpark && !force_tlr) |=> (mode_q == LS_PARKED && $stable(kind_q))); // R3

endmodule

// File: rtl/sec_port_park_ctrl.sv
module sec_port_park_ctrl
  import spp_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       bp_tms,
  input  logic [3:0] tap_state,
  input  logic [3:0] tap_next,
  input  logic       req_park_tlr,
  input  logic       req_park_rti,
  input  logic       req_park_pdr,
  input  logic       req_park_pir,
  input  logic       req_unpark,
  input  logic       req_soft_rst,
  output logic       lcl_tms,
  output logic [1:0] port_status
);

  link_st_e   mode_q;
  park_kind_e kind_q, eff_kind;
  logic       sync_hit, park_hit, hold_lvl;

  spp_target_match #(.SYNC_SIDE(1'b1)) u_sync_match (
    .kind     (kind_q),
    .tap_next (tap_next),
    .hit      (sync_hit)
  );

  spp_target_match #(.SYNC_SIDE(1'b0)) u_park_match (
    .kind     (eff_kind),
    .tap_next (tap_next),
    .hit      (park_hit)
  );

  spp_park_fsm u_fsm (
    .tck          (tck),
    .trst_n       (trst_n),
    .tap_state    (tap_state),
    .req_park_tlr (req_park_tlr),
    .req_park_rti (req_park_rti),
    .req_park_pdr (req_park_pdr),
    .req_park_pir (req_park_pir),
    .req_unpark   (req_unpark),
    .req_soft_rst (req_soft_rst),
    .sync_hit     (sync_hit),
    .park_hit     (park_hit),
    .eff_kind     (eff_kind),
    .mode_q       (mode_q),
    .kind_q       (kind_q)
  );

  // only a chain resting in Test-Logic-Reset sees a high level
  assign hold_lvl    = (mode_q == LS_PARKED) && (kind_q == PK_TLR);
  assign lcl_tms     = (mode_q == LS_CONN) ? bp_tms : hold_lvl;
  assign port_status = mode_q;

  AST_WAIT_LOW: assert property (@(posedge tck) disable iff (!trst_n)
    (port_status == LS_WAIT) |-> !lcl_tms); // R4

  AST_STATUS_LEGAL: assert property (@(posedge tck) disable iff (!trst_n)
    port_status != 2'b11); // R10

endmodule

// File: tb/sec_port_park_ctrl_tb.sv
`timescale 1ns/1ps
module sec_port_park_ctrl_tb;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       bp_tms = 1'b0;
  logic [3:0] tap_state = 4'd0;
  logic [3:0] tap_next = 4'd0;
  logic       req_park_tlr = 1'b0, req_park_rti = 1'b0, req_park_pdr = 1'b0;
  logic       req_park_pir = 1'b0, req_unpark = 1'b0, req_soft_rst = 1'b0;
  logic       lcl_tms;
  logic [1:0] port_status;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] cur = 4'd0, loc = 4'd0;
  int m_mode = 0, m_kind = 0, m_pend = 0, m_pk = 0;

  localparam int SB_NONE = 0, SB_TLR = 1, SB_RTI = 2, SB_PDR = 3, SB_PIR = 4,
                 SB_UNPARK = 5, SB_SOFT = 6;

  always #2 tck = ~tck;

  sec_port_park_ctrl u_dut (
    .tck(tck), .trst_n(trst_n), .bp_tms(bp_tms), .tap_state(tap_state),
    .tap_next(tap_next), .req_park_tlr(req_park_tlr), .req_park_rti(req_park_rti),
    .req_park_pdr(req_park_pdr), .req_park_pir(req_park_pir),
    .req_unpark(req_unpark), .req_soft_rst(req_soft_rst),
    .lcl_tms(lcl_tms), .port_status(port_status)
  );

  function automatic logic [3:0] tnx(logic [3:0] s, logic t);
    case (s)
      4'd0:  return t ? 4'd0  : 4'd1;
      4'd1:  return t ? 4'd2  : 4'd1;
      4'd2:  return t ? 4'd9  : 4'd3;
      4'd3:  return t ? 4'd5  : 4'd4;
      4'd4:  return t ? 4'd5  : 4'd4;
      4'd5:  return t ? 4'd8  : 4'd6;
      4'd6:  return t ? 4'd7  : 4'd6;
      4'd7:  return t ? 4'd8  : 4'd4;
      4'd8:  return t ? 4'd2  : 4'd1;
      4'd9:  return t ? 4'd0  : 4'd10;
      4'd10: return t ? 4'd12 : 4'd11;
      4'd11: return t ? 4'd12 : 4'd11;
      4'd12: return t ? 4'd15 : 4'd13;
      4'd13: return t ? 4'd14 : 4'd13;
      4'd14: return t ? 4'd15 : 4'd11;
      default: return t ? 4'd2 : 4'd1;
    endcase
  endfunction

  function automatic int kst(int k);
    return (k == 1) ? 1 : (k == 2) ? 6 : (k == 3) ? 13 : 0;
  endfunction

  function automatic int syn(int k);
    return (k <= 1) ? 1 : kst(k);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_kind = 0; m_pend = 0; m_pk = 0;
  endtask

  task automatic model_edge(input logic [3:0] st, input logic [3:0] nx, input int sb);
    if (st == 4'd0 || sb == SB_SOFT) begin
      m_mode = 0; m_kind = 0; m_pend = 0;
    end else if (m_mode == 2) begin
      if (sb == SB_TLR) begin
        m_mode = 0; m_kind = 0; m_pend = 0;
      end else begin
        int ev = m_pend, ek = m_pk;
        if (sb >= SB_RTI && sb <= SB_PIR) begin ev = 1; ek = sb - 1; end
        if (ev != 0) begin
          if (int'(nx) == kst(ek)) begin m_mode = 0; m_kind = ek; m_pend = 0; end
          else begin m_pend = 1; m_pk = ek; end
        end
      end
    end else if (m_mode == 0) begin
      if (sb == SB_UNPARK) m_mode = 1;
    end else begin
      if (int'(nx) == syn(m_kind)) m_mode = 2;
    end
  endtask

  // one bridge clock: drive after rising edge, check after falling edge
  task automatic step(input logic t, input int sb);
    logic lt;
    logic [3:0] nx;
    string tag;
    nx = tnx(cur, t);
    bp_tms = t; tap_state = cur; tap_next = nx;
    req_park_tlr = (sb == SB_TLR); req_park_rti = (sb == SB_RTI);
    req_park_pdr = (sb == SB_PDR); req_park_pir = (sb == SB_PIR);
    req_unpark = (sb == SB_UNPARK); req_soft_rst = (sb == SB_SOFT);
    @(negedge tck); #1;
    model_edge(cur, nx, sb);
    {req_park_tlr, req_park_rti, req_park_pdr, req_park_pir, req_unpark, req_soft_rst} = '0;
    tag = (m_mode == 2) ? "R6" : (m_mode == 1) ? "R4" : "R3";
    chk(int'(port_status) == m_mode, "R10 status", int'(port_status), m_mode);
    chk(lcl_tms == ((m_mode == 2) ? t : (m_mode == 0 && m_kind == 0)), tag,
        int'(lcl_tms), (m_mode == 2) ? int'(t) : int'(m_mode == 0 && m_kind == 0));
    lt = lcl_tms;
    @(posedge tck);
    cur = nx;
    loc = tnx(loc, lt);
    if (m_mode == 2) chk(loc == cur, "R6 local tracks bridge", int'(loc), int'(cur));
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    #5;
    chk(port_status == 2'b00, "R1 reset status", int'(port_status), 0);
    chk(lcl_tms == 1'b1, "R1 reset tms", int'(lcl_tms), 1);
    @(posedge tck); #1;
    trst_n = 1'b1; cur = 4'd0; loc = 4'd0; model_reset();

    // R2: bridge in Test-Logic-Reset keeps the port parked high
    step(1'b0, SB_UNPARK);
    chk(port_status == 2'b00, "R2 tlr overrides unpark", int'(port_status), 0);
    // R4 unpark from Test-Logic-Reset kind
    step(1'b0, SB_UNPARK);
    chk(port_status == 2'b01, "R4 waiting", int'(port_status), 1);
    step(1'b1, SB_NONE);
    step(1'b0, SB_NONE);
    step(1'b1, SB_NONE);
    step(1'b1, SB_NONE);
    chk(port_status == 2'b01, "R5 still waiting", int'(port_status), 1);
    step(1'b0, SB_NONE);
    chk(port_status == 2'b10, "R5 connected at idle", int'(port_status), 2);

    // R7: pending Pause-DR park
    step(1'b1, SB_PDR);
    chk(port_status == 2'b10, "R7 pending keeps link", int'(port_status), 2);
    step(1'b0, SB_NONE);
    step(1'b1, SB_NONE);
    step(1'b0, SB_NONE);
    chk(port_status == 2'b00, "R7 parked in pause-dr", int'(port_status), 0);
    step(1'b1, SB_NONE);
    chk(lcl_tms == 1'b0, "R3 pause hold low", int'(lcl_tms), 0);
    step(1'b0, SB_TLR);
    chk(port_status == 2'b00 && lcl_tms == 1'b0, "R8 tlr park ignored when parked",
        int'(lcl_tms), 0);
    chk(loc == 4'd6, "R8 local chain untouched", int'(loc), 6);
    step(1'b1, SB_UNPARK);
    step(1'b1, SB_NONE);
    step(1'b0, SB_NONE);
    chk(port_status == 2'b01, "R5 idle is wrong sync for pause-dr", int'(port_status), 1);
    step(1'b1, SB_NONE);
    step(1'b0, SB_NONE);
    step(1'b1, SB_NONE);
    step(1'b0, SB_NONE);
    chk(port_status == 2'b10, "R5 connected at pause-dr", int'(port_status), 2);

    // R7 park in Run-Test/Idle, then R8 unpark ignored while connected
    step(1'b0, SB_RTI);
    step(1'b1, SB_UNPARK);
    step(1'b1, SB_NONE);
    step(1'b0, SB_NONE);
    chk(port_status == 2'b00, "R7 parked in idle", int'(port_status), 0);
    step(1'b1, SB_NONE);
    step(1'b0, SB_UNPARK);
    step(1'b1, SB_NONE);
    step(1'b1, SB_NONE);
    step(1'b0, SB_NONE);
    chk(port_status == 2'b10, "R5 reconnect from idle park", int'(port_status), 2);

    // R9 soft reset
    step(1'b0, SB_SOFT);
    chk(port_status == 2'b00 && lcl_tms == 1'b1, "R9 soft reset parks high",
        int'(lcl_tms), 1);
    for (int i = 0; i < 5; i++) step(1'b0, SB_NONE);
    chk(loc == 4'd0, "R9 local reset within five", int'(loc), 0);

    // R2 bridge walks into Test-Logic-Reset while connected
    step(1'b0, SB_UNPARK);
    step(1'b0, SB_NONE);
    chk(port_status == 2'b10, "R5 connected", int'(port_status), 2);
    for (int i = 0; i < 4; i++) step(1'b1, SB_NONE);
    chk(port_status == 2'b00 && lcl_tms == 1'b1, "R2 bridge reset parks",
        int'(port_status), 0);

    // R1 asynchronous reset while connected
    step(1'b0, SB_NONE);
    step(1'b0, SB_UNPARK);
    step(1'b0, SB_NONE);
    trst_n = 1'b0; #0.5;
    chk(port_status == 2'b00 && lcl_tms == 1'b1, "R1 async reset", int'(port_status), 0);
    @(posedge tck);
    cur = 4'd0; loc = tnx(loc, 1'b1); #1;
    trst_n = 1'b1; model_reset();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic t;
      int r, sb;
      t = (($urandom % 10) < 3);
      r = $urandom % 100;
      sb = SB_NONE;
      if (r < 2) sb = SB_SOFT;
      else if (r < 5) sb = SB_TLR;
      else if (r < 9) sb = SB_RTI;
      else if (r < 13) sb = SB_PDR;
      else if (r < 17) sb = SB_PIR;
      else if (r < 40) sb = SB_UNPARK;
      if (sb == SB_UNPARK && !(m_mode == 0 && (m_kind != 0 || loc == 4'd0))) sb = SB_NONE;
      if ((sb == SB_SOFT || sb == SB_TLR) && m_mode != 2 && loc != 4'd0) sb = SB_NONE;
      step(t, sb);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule